// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask

This block gathers the interrupt sources of a two-channel disk controller. Each channel has two sources: a drive request line and a bus-master completion pulse. The block turns each source into a status bit. It applies a mask bit to each channel and drives one interrupt line per channel. The polarity of each line comes from a configuration input.

The host sees the state through two byte-wide read ports, which share one address bit. The first byte carries only the status of channel 0. The second byte carries four things: the channel 1 status, both mask bits, and a read-only strap that reports whether a legacy header is present. The host can write only the two mask bits. A bus-master status bit stays set until an acknowledge input clears it. A drive status bit follows its request line with one register stage of delay.

The reset input is asynchronous and active-low. The block releases it internally through a two-stage synchronizer.

Top module: `irq_stat_mask`

## Requirements
- R1: While reset is held, every status bit and both mask bits read 0. The mask byte then shows only the strap in bit 4, and each line sits at its inactive level (low when `pol_low_i` is 0, high when it is 1).
- R2: A channel's drive status bit takes the value its `drv_irq_i` bit had at the previous rising clock edge.
- R3: A `bm_done_i` pulse sets the channel's bus-master status on the next edge, and the bit holds until a `bm_ack_i`. If done and ack arrive in the same cycle, set wins.
- R4: With `addr_i` = 0, `rd_data_o` bit 0 is the channel 0 drive status and bit 1 is the channel 0 bus-master status. Bits 7..2 read 0.
- R5: With `addr_i` = 1, `rd_data_o` is laid out as follows:
  - bit 0 is the channel 0 mask and bit 1 is the channel 1 mask;
  - bit 2 is the channel 1 drive status and bit 3 is the channel 1 bus-master status;
  - bit 4 is `legacy_hdr_i`;
  - bits 7..5 read 0.
- R6: A write with `addr_i` = 1 loads `wr_data_i` bits 1..0 into the masks (1 = masked), and its other bits have no effect. A write with `addr_i` = 0 changes nothing.
- R7: A channel's line is active when either of its status bits is set and its mask bit is 0. Otherwise the line is inactive.
- R8: When a channel's `pol_low_i` bit is 0, its line is active-high. When that bit is 1, the line is active-low.
- R9: Masking a channel leaves its status bits unchanged and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_irq_i | input | 2 | Drive interrupt level per channel |
| bm_done_i | input | 2 | Bus-master completion pulse per channel |
| bm_ack_i | input | 2 | Bus-master status acknowledge per channel |
| pol_low_i | input | 2 | 1 selects an active-low line for that channel |
| legacy_hdr_i | input | 1 | Legacy header present strap |
| addr_i | input | 1 | Register select: 0 status byte, 1 mask byte |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the selected register |
| irq_o | output | 2 | Interrupt line per channel |

## Verification
The main test sweeps all 256 combinations of drive level, bus-master status, mask and polarity for both channels. Each combination checks both lines and both read bytes. This separates the OR of the two sources from the masking and from the polarity inversion, and it exposes any swap of bit positions between the channels. Every mask write also sets the read-only bits to 1, so a stray write to those bits shows up in the reads.

Directed cases cover the remaining corners:
- done and ack arriving in the same cycle;
- a bus-master bit that must hold across idle cycles;
- a write to the status address, which must change nothing;
- the state held during reset.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCH = 2;
  localparam int DW  = 8;

  typedef enum logic {
    REG_STAT = 1'b0,
    REG_MASK = 1'b1
  } reg_sel_e;

  // Bit positions that host software decodes
  localparam int STAT_DRV0 = 0;
  localparam int STAT_BM0  = 1;
  localparam int MSK_M0    = 0;
  localparam int MSK_M1    = 1;
  localparam int MSK_DRV1  = 2;
  localparam int MSK_BM1   = 3;
  localparam int MSK_LEG   = 4;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/irq_chan.sv
module irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_i,
  input  logic done_i,
  input  logic ack_i,
  input  logic mask_i,
  input  logic pol_low_i,
  output logic drv_st_o,
  output logic bm_st_o,
  output logic line_o
);
  logic drv_q, drv_d;
  logic bm_q, bm_d;
  logic active;

  // next state: completion set dominates acknowledge
  always_comb begin
    drv_d = drv_i;
    bm_d  = bm_q;
    if (ack_i)  bm_d = 1'b0;
    if (done_i) bm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      bm_q  <= 1'b0;
    end else begin
      drv_q <= drv_d;
      bm_q  <= bm_d;
    end
  end

  always_comb begin
    active = (drv_q | bm_q) & ~mask_i;
    line_o = active ^ pol_low_i;
  end

  assign drv_st_o = drv_q;
  assign bm_st_o  = bm_q;

  // R3: completion pulse always leaves the bit set
  p_bm_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> bm_st_o);
  // R3: acknowledge alone clears
  p_bm_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !done_i) |=> !bm_st_o);
  // R3: no event, no change
  p_bm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !done_i) |=> $stable(bm_st_o));
  // R7 R8: masked channel sits at its inactive level
  p_masked_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |-> (line_o == pol_low_i));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [NCH-1:0] mask_o
);
  logic [NCH-1:0] mask_q, mask_d;
  logic           mask_ce;
  logic           unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[DW-1:NCH];

  always_comb begin
    mask_ce = wr_en_i && (addr_i == REG_MASK);
    mask_d  = mask_ce ? wr_data_i[NCH-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R6: write to status address leaves masks alone
  p_stat_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == REG_STAT) |=> $stable(mask_o));
  // R6: no write, no change
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_pkg::*;
(
  input  logic           addr_i,
  input  logic [NCH-1:0] drv_st_i,
  input  logic [NCH-1:0] bm_st_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           legacy_i,
  output logic [DW-1:0]  rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (addr_i == REG_STAT) begin
      rd_data_o[STAT_DRV0] = drv_st_i[0];
      rd_data_o[STAT_BM0]  = bm_st_i[0];
    end else begin
      rd_data_o[MSK_M0]   = mask_i[0];
      rd_data_o[MSK_M1]   = mask_i[1];
      rd_data_o[MSK_DRV1] = drv_st_i[1];
      rd_data_o[MSK_BM1]  = bm_st_i[1];
      rd_data_o[MSK_LEG]  = legacy_i;
    end
  end

  // R4 R5: undefined bits read zero
  always_comb begin
    a_stat_hi_zero_r4: assert (addr_i != REG_STAT || rd_data_o[DW-1:2] == '0);
    a_mask_hi_zero_r5: assert (addr_i != REG_MASK || rd_data_o[DW-1:5] == '0);
  end
endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] drv_irq_i,
  input  logic [1:0] bm_done_i,
  input  logic [1:0] bm_ack_i,
  input  logic [1:0] pol_low_i,
  input  logic       legacy_hdr_i,
  input  logic       addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic [1:0] irq_o
);
  logic           rst_ns;
  logic [NCH-1:0] mask;
  logic [NCH-1:0] drv_st;
  logic [NCH-1:0] bm_st;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_ns), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .mask_o(mask)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irq_chan u_ch (
      .clk(clk), .rst_n(rst_ns),
      .drv_i(drv_irq_i[c]), .done_i(bm_done_i[c]), .ack_i(bm_ack_i[c]),
      .mask_i(mask[c]), .pol_low_i(pol_low_i[c]),
      .drv_st_o(drv_st[c]), .bm_st_o(bm_st[c]), .line_o(irq_o[c])
    );
  end

  irq_rd_mux u_rd (
    .addr_i(addr_i), .drv_st_i(drv_st), .bm_st_i(bm_st), .mask_i(mask),
    .legacy_i(legacy_hdr_i), .rd_data_o(rd_data_o)
  );

  // R9: masking never disturbs latched bus-master status
  p_mask_keeps_bm_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (bm_done_i == '0 && bm_ack_i == '0) |=> $stable(bm_st));
  // R2: drive status lags its request by one edge
  p_drv_follow_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (drv_st == $past(drv_irq_i)));
endmodule

// File: tb/sim_irq_stat_mask.sv
`timescale 1ns/1ps
module sim_irq_stat_mask;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] drv_irq, bm_done, bm_ack, pol_low;
  logic       legacy, addr, wr_en;
  logic [7:0] wr_data, rd_data;
  logic [1:0] irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_stat_mask u0 (
    .clk(clk), .rst_n(rst_n), .drv_irq_i(drv_irq), .bm_done_i(bm_done),
    .bm_ack_i(bm_ack), .pol_low_i(pol_low), .legacy_hdr_i(legacy),
    .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [1:0] d, b, m, p, act;
    rst_n = 1'b0; drv_irq = '0; bm_done = '0; bm_ack = '0; pol_low = '0;
    legacy = 1'b1; addr = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(1'b0, v); chk("R1 status", v, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'h10);
    chk("R1 irq", {6'b0, irq}, 8'h00);
    pol_low = 2'b11; #1;
    chk("R1 irq pol", {6'b0, irq}, 8'h03);
    pol_low = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive sweep R2 R4 R5 R6 R7 R8
    for (int n = 0; n < 256; n++) begin
      d = {n[4], n[0]}; b = {n[5], n[1]}; m = {n[6], n[2]}; p = {n[7], n[3]};
      drv_irq = d; pol_low = p; legacy = n[0] ^ n[7];
      bm_done = b; bm_ack = ~b;
      wr_en = 1'b1; addr = 1'b1; wr_data = {6'b111111, m};
      @(negedge clk);
      wr_en = 1'b0; bm_done = '0; bm_ack = '0; wr_data = '0;
      act = (d | b) & ~m;
      chk("R7 R8 irq", {6'b0, irq}, {6'b0, act ^ p});
      rd(1'b0, v); chk("R2 R3 R4 status", v, {6'b0, b[0], d[0]});
      rd(1'b1, v); chk("R5 R6 R9 mask", v, {3'b0, legacy, b[1], d[1], m});
    end

    // R3: set wins over ack, then holds, then clears
    @(negedge clk);
    wr_en = 1'b1; addr = 1'b1; wr_data = 8'h03; drv_irq = '0; pol_low = '0;
    bm_ack = 2'b11; @(negedge clk); bm_ack = '0; wr_en = 1'b0;
    bm_done = 2'b11; bm_ack = 2'b11;
    @(negedge clk); bm_done = '0; bm_ack = '0;
    rd(1'b0, v); chk("R3 set wins", v, 8'h02);
    repeat (5) @(negedge clk);
    rd(1'b1, v); chk("R3 R9 hold masked", v, {3'b0, legacy, 4'b1011});
    chk("R7 masked idle", {6'b0, irq}, 8'h00);

    // R6: write to status address ignored
    wr_en = 1'b1; addr = 1'b0; wr_data = 8'hFC;
    @(negedge clk); wr_en = 1'b0;
    rd(1'b1, v); chk("R6 stat write ignored", v, {3'b0, legacy, 4'b1011});
    rd(1'b0, v); chk("R6 stat unchanged", v, 8'h02);

    // unmask -> lines fire from bm only
    wr_en = 1'b1; addr = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 unmasked", {6'b0, irq}, 8'h03);
    bm_ack = 2'b01; @(negedge clk); bm_ack = '0;
    chk("R3 ack ch0", {6'b0, irq}, 8'h02);
    rd(1'b0, v); chk("R3 ack status", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule